// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 128-byte byte-addressed memory reached over a two-wire serial bus. Both bus lines are brought into a faster system clock through a synchronizer. START and STOP are recognised from SDA edges while SCL is high, and the bytes of a transfer are shifted in on SCL rising edges. The slave answers through a single pull-low enable, so the line itself is formed outside the block as an open-drain wired AND.

A write transfer has three parts: the device-address byte with the direction bit clear, a word-address byte, and one or more data bytes. The data bytes are held in a four-entry page buffer, and the array is updated only when a STOP closes the sequence. A timed busy window then follows, and during it the slave ignores the bus completely. A read transfer returns bytes from the current address and steps the address forward after each one. A repeated START lets the master set the address with a write header and then read from that address.

Top module: `tws_slave`

## Requirements
- R1: After reset the pull-low enable is 0, the slave is idle and every memory byte reads as 0x00.
- R2: With SCL high, SDA falling is a START and SDA rising is a STOP. Any other bus bit is sampled on the SCL rising edge, most significant bit first.
- R3: The first byte after a START holds a 7-bit device address followed by a direction bit, where 1 means read. If the address equals DEV_ADDR, the slave pulls SDA low for the whole ninth clock. If it does not, the slave gives no acknowledge and stays silent until the next START.
- R4: The pull-low enable changes only while SCL is low, after the SCL falling edge.
- R5: In a write header, the second byte is acknowledged and its lower 7 bits become the current address. Bit 7 is ignored.
- R6: Each data byte of a write is acknowledged and stored in the page buffer at the slot given by the address bits [1:0]. Those bits then advance modulo 4 while bits [6:2] stay fixed, so a fifth byte overwrites the first. The array changes only at the STOP.
- R7: A STOP that ends a write before any data byte changes nothing and starts no busy window. The next header is acknowledged at once.
- R8: After a committing STOP, for BUSY_CLKS system clocks, the slave keeps SDA released and acknowledges nothing, START included. After that window it answers normally.
- R9: A read shifts out the byte at the current address and then increments the address, wrapping from 127 to 0. An acknowledge from the master continues the read with the next byte. A not-acknowledge ends the read.
- R10: A START in any state outside the busy window restarts device-address reception and discards buffered bytes that have not been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the wired-AND bus |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench writes five bytes into a page starting two below its end. This checks that slot order wraps inside the page: a design that carried into bits [6:2], or that did not overwrite the first slot, would read back the wrong bytes at 124 to 127. A sequential read across address 127 must return address 0, which catches an address counter that saturates or carries into the wrong width. The bench probes the bus right after a committing STOP and expects no acknowledge. It also expects an immediate acknowledge after a STOP that followed only a word address, and after a repeated START that abandoned a buffered byte. This exposes a design that starts the busy window or commits data in the wrong cases. Finally, a per-clock monitor flags any change of the pull enable while SCL is high.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int TWS_AW = 7;
  localparam int TWS_PW = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } tws_state_e;

  // next slot inside the same page: low bits wrap, page bits stay
  function automatic logic [TWS_AW-1:0] page_step(input logic [TWS_AW-1:0] a);
    return {a[TWS_AW-1:TWS_PW], a[TWS_PW-1:0] + 1'b1};
  endfunction

  // sequential read address, wraps at the top of the array
  function automatic logic [TWS_AW-1:0] seq_step(input logic [TWS_AW-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tws_store.sv
module tws_store
  import tws_pkg::*;
#(
  parameter int AW        = TWS_AW,
  parameter int PW        = TWS_PW,
  parameter int BUSY_CLKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_clr,
  input  logic             buf_wr,
  input  logic [PW-1:0]    buf_idx,
  input  logic [7:0]       buf_data,
  input  logic             commit_req,
  input  logic [AW-PW-1:0] page_base,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             commit
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PW;
  localparam int CW    = $clog2(BUSY_CLKS + 1);

  logic [7:0]       mem   [DEPTH];
  logic [7:0]       stage [SLOTS];
  logic [SLOTS-1:0] valid;
  logic [CW-1:0]    cnt;

  assign busy    = (cnt != '0);
  assign commit  = commit_req && (|valid) && !busy;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < SLOTS; j++) stage[j] <= '0;
      valid <= '0;
      cnt   <= '0;
    end else if (commit) begin
      for (int j = 0; j < SLOTS; j++)
        if (valid[j]) mem[{page_base, PW'(j)}] <= stage[j];
      valid <= '0;
      cnt   <= CW'(BUSY_CLKS);
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      if (buf_clr) valid <= '0;
      else if (buf_wr) begin
        stage[buf_idx] <= buf_data;
        valid[buf_idx] <= 1'b1;
      end
    end
  end

  // R8: a busy window opens only from a commit
  a_r8_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> $past(commit));
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         BUSY_CLKS   = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull_o
);
  localparam int AW = TWS_AW;
  localparam int PW = TWS_PW;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit, buf_wr, buf_clr, byte_end;
  logic [7:0] rd_data;

  tws_state_e    state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txbyte;
  logic [AW-1:0] addr;
  logic          rw, sda_low;

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  // named bus events for the store and for the assertions
  assign byte_end = scl_fall && (bitcnt == 4'd8) && !busy && !start_det && !stop_det;
  assign buf_wr   = byte_end && (state == ST_WDATA);
  assign buf_clr  = start_det && !busy;

  tws_store #(.AW(AW), .PW(PW), .BUSY_CLKS(BUSY_CLKS)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_wr(buf_wr),
    .buf_idx(addr[PW-1:0]), .buf_data(shreg), .commit_req(stop_det),
    .page_base(addr[AW-1:PW]), .rd_addr(addr), .rd_data(rd_data),
    .busy(busy), .commit(commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txbyte <= '0;
      addr <= '0; rw <= 1'b0; sda_low <= 1'b0;
    end else if (busy) begin
      state <= ST_IDLE; bitcnt <= '0; sda_low <= 1'b0;
    end else if (start_det) begin
      state <= ST_DEV; bitcnt <= '0; sda_low <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; bitcnt <= '0; sda_low <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == ST_DEV) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw <= shreg[0]; sda_low <= 1'b1; state <= ST_DEV_ACK;
              end else state <= ST_IDLE;
            end else if (state == ST_WADDR) begin
              addr <= shreg[AW-1:0]; sda_low <= 1'b1; state <= ST_WADDR_ACK;
            end else begin
              addr <= page_step(addr); sda_low <= 1'b1; state <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_low <= 1'b0;
            if (state == ST_DEV_ACK && rw) begin
              txbyte <= rd_data; sda_low <= ~rd_data[7];
              bitcnt <= 4'd1; state <= ST_RDATA;
            end else if (state == ST_DEV_ACK) state <= ST_WADDR;
            else state <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_low <= 1'b0; bitcnt <= '0;
              addr <= seq_step(addr); state <= ST_RACK;
            end else begin
              sda_low <= ~txbyte[6];
              txbyte  <= {txbyte[6:0], 1'b0};
              bitcnt  <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) shreg[0] <= sda_s;
          else if (scl_fall) begin
            if (!shreg[0]) begin
              txbyte <= rd_data; sda_low <= ~rd_data[7];
              bitcnt <= 4'd1; state <= ST_RDATA;
            end else state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_pull_o = sda_low;

  // R4: the pull enable moves only in the low phase of SCL
  a_r4_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) |-> !scl_s);
  // R8: SDA stays released while the store is busy
  a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_low);
  // R6: the array is written only on a STOP
  a_r6_commit_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_det);
  // R6: buffering a byte never leaves the current page
  a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));
  // R3: an address acknowledge follows only a matching device byte
  a_r3_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV_ACK && $past(state) == ST_DEV) |-> $past(shreg[7:1]) == DEV_ADDR);
endmodule

// File: tb/test_tws_slave.sv
module test_tws_slave;
  localparam int Q    = 10;
  localparam int BUSY = 1000;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int errors = 0, checks = 0;
  int ref_mem [128];
  int ref_addr = 0;
  bit quiet = 1'b0;
  int quiet_viol = 0, r4_viol = 0;
  logic prev_pull = 1'b0, prev_scl = 1'b1;

  always #10 clk = ~clk;

  tws_slave #(.DEV_ADDR(DEV), .BUSY_CLKS(BUSY)) i_tws_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull_o(sda_pull));

  // per-clock comparison against the bus rules
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull !== prev_pull && scl && prev_scl) r4_viol++;
      if (quiet && sda_pull) quiet_viol++;
    end
    prev_pull = sda_pull;
    prev_scl  = scl;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q();
  endtask

  task automatic bus_stop();
    sda_m = 0; q(); scl = 1; q(); sda_m = 1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1; q(); q(); scl = 0; q();
    end
    sda_m = 1; q(); scl = 1; q(); acked = !sda_line; q(); scl = 0; q();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; q(); scl = 1; q(); b[i] = sda_line; q(); scl = 0; q();
    end
    sda_m = nack; q(); scl = 1; q(); q(); scl = 0; q(); sda_m = 1;
  endtask

  task automatic expect_ack(input logic [7:0] b, input bit exp, input string req);
    bit a;
    send_byte(b, a);
    check(a == exp, req, a, exp);
  endtask

  // staged write into the model, applied only when the STOP arrives
  task automatic model_write(input int start, input int n, input int vals [8]);
    int page, pos;
    page = start & 'h7C;
    pos  = start & 3;
    for (int k = 0; k < n; k++) begin
      ref_mem[page + pos] = vals[k];
      pos = (pos + 1) % 4;
    end
    ref_addr = page + pos;
  endtask

  task automatic read_expect(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      check(b == ref_mem[ref_addr][7:0], req, b, ref_mem[ref_addr]);
      ref_addr = (ref_addr + 1) % 128;
    end
  endtask

  task automatic set_addr(input logic [7:0] wa, input string req);
    bus_start();
    expect_ack({DEV, 1'b0}, 1'b1, req);
    expect_ack(wa, 1'b1, req);
    ref_addr = wa & 'h7F;
  endtask

  task automatic finish_run();
    check(r4_viol == 0, "R4 pull changed while SCL high", r4_viol, 0);
    check(quiet_viol == 0, "R8 pull asserted during busy window", quiet_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v [8];
    for (int k = 0; k < 128; k++) ref_mem[k] = 0;
    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R1 released in reset", sda_pull, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);

    // R3 R5 R6: write two bytes at 5, then probe the busy window (R8)
    set_addr(8'h05, "R5 word address ack");
    expect_ack(8'hA1, 1'b1, "R6 data ack");
    expect_ack(8'hA2, 1'b1, "R6 data ack");
    v = '{'hA1, 'hA2, 0, 0, 0, 0, 0, 0};
    bus_stop();
    model_write(5, 2, v);
    quiet = 1;
    bus_start();
    expect_ack({DEV, 1'b0}, 1'b0, "R8 no ack while busy");
    bus_stop();
    repeat (BUSY + 50) @(negedge clk);
    quiet = 0;

    // R10 R9 R2: random read through repeated START
    set_addr(8'h05, "R8 ack after busy window");
    bus_start();
    expect_ack({DEV, 1'b1}, 1'b1, "R10 repeated start read header");
    read_expect(2, "R9 R2 read back");
    bus_stop();

    // R6: five bytes from 126 wrap within page 124..127
    set_addr(8'h7E, "R6 page header");
    for (int k = 0; k < 5; k++) expect_ack(8'(8'h11 * (k + 1)), 1'b1, "R6 data ack");
    v = '{'h11, 'h22, 'h33, 'h44, 'h55, 0, 0, 0};
    bus_stop();
    model_write('h7E, 5, v);
    repeat (BUSY + 50) @(negedge clk);

    // R9 R1: sequential read from 124 across 127 to 0
    set_addr(8'h7C, "R9 header");
    bus_start();
    expect_ack({DEV, 1'b1}, 1'b1, "R9 read header");
    read_expect(5, "R9 R1 sequential wrap");
    bus_stop();

    // R3: mismatching device address gets no ack, nor does the next byte
    bus_start();
    expect_ack({DEV ^ 7'h01, 1'b0}, 1'b0, "R3 mismatch no ack");
    expect_ack(8'h00, 1'b0, "R3 silent after mismatch");
    bus_stop();

    // R7: STOP after only the word address commits nothing, no busy
    set_addr(8'h10, "R7 header");
    bus_stop();
    bus_start();
    expect_ack({DEV, 1'b1}, 1'b1, "R7 immediate ack, no busy");
    read_expect(1, "R7 address kept");
    bus_stop();

    // R10: buffered byte dropped by a repeated START
    set_addr(8'h20, "R10 header");
    expect_ack(8'h99, 1'b1, "R10 data ack");
    bus_start();
    bus_stop();
    bus_start();
    expect_ack({DEV, 1'b0}, 1'b1, "R10 no busy after abort");
    expect_ack(8'h20, 1'b1, "R10 address ack");
    ref_addr = 'h20;
    bus_start();
    expect_ack({DEV, 1'b1}, 1'b1, "R10 read header");
    read_expect(1, "R10 byte not committed");
    bus_stop();

    // R5: bit 7 of the word address is ignored
    set_addr(8'h85, "R5 header msb set");
    bus_start();
    expect_ack({DEV, 1'b1}, 1'b1, "R5 read header");
    read_expect(1, "R5 msb ignored");
    bus_stop();

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule